// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block lets a clocked host read and write a 32K x 8 asynchronous static RAM. It turns one host request into a timed sequence of active-low select, write-strobe and output-strobe levels. It also drives a 15-bit address bus and an 8-bit data bus. The data bus is split into an outbound byte, an inbound byte and a driver enable, and the pad logic outside the block joins them. Each phase of a memory cycle lasts a whole number of clock cycles, set by a parameter. The designer picks each length by rounding the memory's nanosecond limits up to the chosen clock period.

The host side is a valid/ready request stream with write flag, address and write data. A request is taken on the clock edge where `req_valid` and `req_ready` are both high. Holding `req_valid` high while `req_ready` is low has no effect. Only one request is in flight at a time. Reads return their byte on a one-cycle `rsp_valid` pulse. The response path has no back-pressure, so the host must take the byte in the cycle it appears.

Writes are controlled by the write strobe. The output strobe stays high during a write, and the controller drives the data pins only while the write strobe is low. Every read ends with a bus turnaround, so the memory's outputs go high-impedance before the controller can drive again.

Top module: `asram_ctrl`

## Requirements
- R1: After reset, select, write strobe and output strobe are all high (inactive), the data driver enable is low, `req_ready` is high and `rsp_valid` is low.
- R2: All strobes are active low. While select is high, the write and output strobes are both high. Select low with write strobe low is a write. Select low with write strobe high and output strobe low is a read.
- R3: An accepted write first spends TURN_CYC cycles with select low, both other strobes high and the drivers off. It then spends WPULSE_CYC cycles with the write strobe low and the drivers on, carrying the captured byte. The output strobe stays high, and select falls at least one cycle before the write strobe.
- R4: The data drivers switch off in the same cycle the write strobe rises, and they are never on while the output strobe is low.
- R5: An accepted read first spends SETUP_CYC cycles with select low and both other strobes high. It then spends ACCESS_CYC cycles with select and output strobe low. The inbound byte is sampled on the clock edge that ends the access phase.
- R6: `rsp_valid` is high for exactly one cycle, the cycle after the access phase ends, and it carries the sampled byte. A write produces no response pulse.
- R7: After the access phase of a read, all strobes are inactive for TURN_CYC cycles before `req_ready` returns.
- R8: `req_ready` is high only while the controller is idle. It falls on the edge that accepts a request and stays low until the last phase of the cycle completes. `req_valid` has no effect while `req_ready` is low.
- R9: Address and write data are captured when the request is accepted. Later changes on `req_addr` and `req_wdata` do not alter the memory address or data pins during that cycle.
- R10: A request presented in the first idle cycle after a transaction is accepted on that cycle's clock edge, with no extra gap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Request byte address |
| req_wdata | input | 8 | Request write byte |
| rsp_valid | output | 1 | One-cycle read-data pulse |
| rsp_rdata | output | 8 | Read byte, valid with rsp_valid |
| mem_sel_n | output | 1 | Memory select, active low |
| mem_wstb_n | output | 1 | Memory write strobe, active low |
| mem_ostb_n | output | 1 | Memory output strobe, active low |
| mem_addr | output | 15 | Memory address bus |
| mem_dout | output | 8 | Outbound data byte toward the pads |
| mem_dout_en | output | 1 | Drive enable for the outbound byte |
| mem_din | input | 8 | Inbound data byte from the pads |

## Verification
The controller is driven with directed writes and reads at address 0 and the top address, using the bytes 00 and FF. It also gets a read of an address that was never written, and a write followed at once by a read of the same address. These checks separate correct data routing from address or data bits that are stuck or swapped. A long seeded random mix of reads and writes is run over both a narrow and the full address range, and it keeps overwriting the same locations, which catches lost writes and stale read data. Some requests keep `req_valid` high with new address and data all through the busy cycle. This separates a controller that captures and holds its request from one that leaks later input or takes a second request. The memory model returns a wrong byte until the last access cycle, so a capture on any earlier edge is seen as wrong data.

// File: rtl/asram_ctrl_pkg.sv
package asram_ctrl_pkg;

  typedef enum logic [2:0] {
    PH_IDLE    = 3'd0,
    PH_WTURN   = 3'd1,
    PH_WPULSE  = 3'd2,
    PH_RSETUP  = 3'd3,
    PH_RACCESS = 3'd4,
    PH_RTURN   = 3'd5
  } phase_e;

  function automatic int max_of4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  // Loaded with (length - 1) on phase entry, counts down to zero.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
  import asram_ctrl_pkg::*;
#(
  parameter int SETUP_CYC  = 1,
  parameter int WPULSE_CYC = 2,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1,
  parameter int CW         = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic          timer_done,
  output phase_e        phase,
  output logic          timer_load,
  output logic [CW-1:0] timer_val,
  output logic          accept,
  output logic          capture
);

  localparam logic [CW-1:0] SETUP_V  = CW'(SETUP_CYC - 1);
  localparam logic [CW-1:0] WPULSE_V = CW'(WPULSE_CYC - 1);
  localparam logic [CW-1:0] ACCESS_V = CW'(ACCESS_CYC - 1);
  localparam logic [CW-1:0] TURN_V   = CW'(TURN_CYC - 1);

  phase_e nxt;

  always_comb begin
    nxt        = phase;
    timer_load = 1'b0;
    timer_val  = '0;
    accept     = 1'b0;
    capture    = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (req_valid) begin
          accept     = 1'b1;
          timer_load = 1'b1;
          if (req_write) begin
            nxt       = PH_WTURN;
            timer_val = TURN_V;
          end else begin
            nxt       = PH_RSETUP;
            timer_val = SETUP_V;
          end
        end
      end
      PH_WTURN: begin
        if (timer_done) begin
          nxt        = PH_WPULSE;
          timer_load = 1'b1;
          timer_val  = WPULSE_V;
        end
      end
      PH_WPULSE: begin
        if (timer_done) nxt = PH_IDLE;
      end
      PH_RSETUP: begin
        if (timer_done) begin
          nxt        = PH_RACCESS;
          timer_load = 1'b1;
          timer_val  = ACCESS_V;
        end
      end
      PH_RACCESS: begin
        if (timer_done) begin
          nxt        = PH_RTURN;
          timer_load = 1'b1;
          timer_val  = TURN_V;
          capture    = 1'b1;
        end
      end
      PH_RTURN: begin
        if (timer_done) nxt = PH_IDLE;
      end
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= nxt;
  end

  // R8: an accepted request leaves idle on the next cycle
  a_r8_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (phase != PH_IDLE));

  // R5: a read access phase is always entered from the setup phase
  a_r5_access_after_setup: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_RACCESS && $past(phase) != PH_RACCESS) |-> $past(phase) == PH_RSETUP);

endmodule

// File: rtl/asram_pin_decode.sv
module asram_pin_decode
  import asram_ctrl_pkg::*;
(
  input  phase_e phase,
  output logic   sel_n,
  output logic   wstb_n,
  output logic   ostb_n,
  output logic   dout_en
);

  always_comb begin
    sel_n   = 1'b1;
    wstb_n  = 1'b1;
    ostb_n  = 1'b1;
    dout_en = 1'b0;
    unique case (phase)
      PH_WTURN:   sel_n = 1'b0;
      PH_WPULSE: begin
        sel_n   = 1'b0;
        wstb_n  = 1'b0;
        dout_en = 1'b1;
      end
      PH_RSETUP:  sel_n = 1'b0;
      PH_RACCESS: begin
        sel_n  = 1'b0;
        ostb_n = 1'b0;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/asram_read_capture.sv
module asram_read_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          capture,
  input  logic [DW-1:0] din,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= capture;
      if (capture) rsp_rdata <= din;
    end
  end

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_ctrl_pkg::*;
#(
  parameter int AW         = 15,
  parameter int DW         = 8,
  parameter int SETUP_CYC  = 1,
  parameter int WPULSE_CYC = 2,
  parameter int ACCESS_CYC = 2,
  parameter int TURN_CYC   = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          mem_sel_n,
  output logic          mem_wstb_n,
  output logic          mem_ostb_n,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_dout,
  output logic          mem_dout_en,
  input  logic [DW-1:0] mem_din
);

  localparam int MAXLEN = max_of4(SETUP_CYC, WPULSE_CYC, ACCESS_CYC, TURN_CYC);
  localparam int CW     = $clog2(MAXLEN) + 1;

  phase_e        phase;
  logic          timer_load;
  logic [CW-1:0] timer_val;
  logic          timer_done;
  logic          accept;
  logic          capture;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (timer_load),
    .load_val (timer_val),
    .done     (timer_done)
  );

  asram_sequencer #(
    .SETUP_CYC  (SETUP_CYC),
    .WPULSE_CYC (WPULSE_CYC),
    .ACCESS_CYC (ACCESS_CYC),
    .TURN_CYC   (TURN_CYC),
    .CW         (CW)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .timer_done (timer_done),
    .phase      (phase),
    .timer_load (timer_load),
    .timer_val  (timer_val),
    .accept     (accept),
    .capture    (capture)
  );

  asram_pin_decode u_pins (
    .phase   (phase),
    .sel_n   (mem_sel_n),
    .wstb_n  (mem_wstb_n),
    .ostb_n  (mem_ostb_n),
    .dout_en (mem_dout_en)
  );

  asram_read_capture #(.DW(DW)) u_rcap (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (capture),
    .din       (mem_din),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  // Request capture: address and data are frozen for the whole memory cycle.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
    end
  end

  assign req_ready = (phase == PH_IDLE);
  assign mem_addr  = addr_q;
  assign mem_dout  = wdata_q;

  // R2: no strobe is active while the memory is deselected
  a_r2_strobes_need_sel: assert property (@(posedge clk) disable iff (!rst_n)
    mem_sel_n |-> (mem_wstb_n && mem_ostb_n));

  // R3: select is already low in the cycle before the write strobe falls
  a_r3_sel_leads_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_wstb_n) |-> $past(!mem_sel_n));

  // R4: drivers are off in the cycle the write strobe returns high
  a_r4_release_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_wstb_n) |-> !mem_dout_en);

  // R4: controller never drives while the memory may drive
  a_r4_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dout_en |-> mem_ostb_n);

  // R6: the response pulse lasts a single cycle
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R8: ready drops right after a request is taken
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R9: address stays put while the memory remains selected
  a_r9_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_sel_n && $past(!mem_sel_n)) |-> $stable(mem_addr));

endmodule

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 15;
  localparam int DW = 8;
  localparam int S_CYC = 1;
  localparam int W_CYC = 2;
  localparam int A_CYC = 2;
  localparam int T_CYC = 1;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          mem_sel_n, mem_wstb_n, mem_ostb_n, mem_dout_en;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_ctrl #(
    .AW(AW), .DW(DW), .SETUP_CYC(S_CYC), .WPULSE_CYC(W_CYC),
    .ACCESS_CYC(A_CYC), .TURN_CYC(T_CYC)
  ) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .mem_sel_n(mem_sel_n),
    .mem_wstb_n(mem_wstb_n), .mem_ostb_n(mem_ostb_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  // ---------------- memory model ----------------
  logic [DW-1:0] mem_model [0:(1<<AW)-1];
  logic [DW-1:0] shadow [int];
  int            low_cnt = 0;

  function automatic logic [DW-1:0] init_val(input logic [AW-1:0] a);
    return a[7:0] ^ {1'b0, a[14:8]} ^ 8'h3C;
  endfunction

  function automatic logic [DW-1:0] exp_val(input logic [AW-1:0] a);
    if (shadow.exists(int'(a))) return shadow[int'(a)];
    return init_val(a);
  endfunction

  initial begin
    for (int i = 0; i < (1<<AW); i++) mem_model[i] = init_val(AW'(i));
  end

  // Counts cycles the output strobe has been low; data only valid in last one.
  always @(posedge clk) begin
    if (!mem_sel_n && !mem_ostb_n && mem_wstb_n) low_cnt <= low_cnt + 1;
    else                                         low_cnt <= 0;
  end

  assign mem_din = (!mem_sel_n && !mem_ostb_n && mem_wstb_n && low_cnt >= A_CYC-1)
                   ? mem_model[mem_addr] : 8'h5A;

  always @(negedge clk) begin
    if (rst_n && !mem_sel_n && !mem_wstb_n)
      mem_model[mem_addr] <= mem_dout_en ? mem_dout : 8'hEE;
    if (rst_n && mem_dout_en && !mem_ostb_n && !mem_sel_n) begin
      miscompares++;
      $display("FAIL R4 contention: act dout_en=1 with output strobe low, exp no overlap");
    end
  end

  // ---------------- checking helpers ----------------
  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s act=%0h exp=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic chk_idle(input string tag);
    chk({tag, " ready"},   req_ready, 1);
    chk({tag, " sel_n"},   mem_sel_n, 1);
    chk({tag, " wstb_n"},  mem_wstb_n, 1);
    chk({tag, " ostb_n"},  mem_ostb_n, 1);
    chk({tag, " dout_en"}, mem_dout_en, 0);
    chk({tag, " rsp_valid"}, rsp_valid, 0);
  endtask

  task automatic add_noise();
    req_valid = 1'b1;
    req_write = 1'($urandom);
    req_addr  = AW'($urandom);
    req_wdata = DW'($urandom);
  endtask

  // Entered at a negedge with the controller idle; leaves at an idle negedge.
  task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit noise);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    chk("R10 ready at request", req_ready, 1);
    @(posedge clk);
    for (int i = 0; i < T_CYC; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (noise) add_noise(); else req_valid = 1'b0;
      end
      chk("R8 ready low in turn", req_ready, 0);
      chk("R3 turn sel_n", mem_sel_n, 0);
      chk("R3 turn wstb_n", mem_wstb_n, 1);
      chk("R3 turn ostb_n", mem_ostb_n, 1);
      chk("R3 turn dout_en", mem_dout_en, 0);
      chk("R9 turn addr", mem_addr, a);
    end
    for (int i = 0; i < W_CYC; i++) begin
      @(negedge clk);
      chk("R3 pulse sel_n", mem_sel_n, 0);
      chk("R3 pulse wstb_n", mem_wstb_n, 0);
      chk("R3 pulse ostb_n", mem_ostb_n, 1);
      chk("R3 pulse dout_en", mem_dout_en, 1);
      chk("R9 pulse dout", mem_dout, d);
      chk("R9 pulse addr", mem_addr, a);
      chk("R6 no rsp on write", rsp_valid, 0);
      chk("R8 ready low in pulse", req_ready, 0);
      if (i == W_CYC-1) req_valid = 1'b0;
    end
    shadow[int'(a)] = d;
    @(negedge clk);
    chk_idle("R4 after write");
  endtask

  task automatic do_read(input logic [AW-1:0] a, input bit noise);
    logic [DW-1:0] e;
    e = exp_val(a);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_wdata = DW'($urandom);
    chk("R10 ready at request", req_ready, 1);
    @(posedge clk);
    for (int i = 0; i < S_CYC; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (noise) add_noise(); else req_valid = 1'b0;
      end
      chk("R5 setup sel_n", mem_sel_n, 0);
      chk("R5 setup ostb_n", mem_ostb_n, 1);
      chk("R5 setup wstb_n", mem_wstb_n, 1);
      chk("R8 ready low in setup", req_ready, 0);
      chk("R9 setup addr", mem_addr, a);
    end
    for (int i = 0; i < A_CYC; i++) begin
      @(negedge clk);
      chk("R5 access sel_n", mem_sel_n, 0);
      chk("R5 access ostb_n", mem_ostb_n, 0);
      chk("R5 access wstb_n", mem_wstb_n, 1);
      chk("R4 access dout_en", mem_dout_en, 0);
      chk("R9 access addr", mem_addr, a);
      chk("R6 no early rsp", rsp_valid, 0);
    end
    for (int i = 0; i < T_CYC; i++) begin
      @(negedge clk);
      chk("R7 turn sel_n", mem_sel_n, 1);
      chk("R7 turn ostb_n", mem_ostb_n, 1);
      chk("R7 turn ready low", req_ready, 0);
      chk("R6 rsp_valid", rsp_valid, (i == 0));
      if (i == 0) chk("R5 read data", rsp_rdata, e);
      if (i == T_CYC-1) req_valid = 1'b0;
    end
    @(negedge clk);
    chk_idle("R7 after read");
  endtask

  task automatic idle_gap(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired act=hung exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    chk_idle("R1 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_idle("R1 after reset");
    chk("R2 idle selects nothing", mem_sel_n, 1);

    // directed corners
    do_write(15'h0000, 8'h00, 0);
    do_write(15'h7FFF, 8'hFF, 0);
    do_read(15'h0000, 0);
    do_read(15'h7FFF, 0);
    do_read(15'h1234, 0);               // never written: initial content
    do_write(15'h2AAA, 8'h55, 0);       // back-to-back write then read
    do_read(15'h2AAA, 0);
    do_write(15'h5555, 8'hA5, 1);       // R8/R9: valid held with new fields
    idle_gap(1);
    chk("R8 no second request taken", mem_sel_n, 1);
    do_read(15'h5555, 1);
    idle_gap(1);
    chk("R8 no request after read", mem_sel_n, 1);

    // seeded random mix
    for (int n = 0; n < 600; n++) begin
      logic [AW-1:0] a;
      bit            nz;
      a  = ($urandom % 4 == 0) ? AW'($urandom) : AW'($urandom % 32);
      nz = ($urandom % 4 == 0);
      if ($urandom % 2) do_write(a, DW'($urandom), nz);
      else              do_read(a, nz);
      if (nz) idle_gap(1);
      else if ($urandom % 3 == 0) idle_gap($urandom % 3);
    end

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule